// File: doc/BRIEF.md
# Sixteen-Pin GPIO Controller with Pin Interrupts

The block is a general-purpose I/O peripheral for sixteen pins, reached through a 16-bit register port. Each register holds one bit per pin. Software chooses for each pin whether it drives or samples. Output levels change only through write-one-to-set and write-one-to-clear strobe registers, and the current output latch can be read back. Input pins pass through a two-flop synchroniser before they can be read or can trigger interrupts.

Each pin can raise an interrupt in one of two ways. The first is on a level, with a chosen polarity. The second is on a rising edge, a falling edge or both; the two edge enables are independent. Edge events are latched in a sticky status bit. A pin reaches the masked status only when its mask bit is clear and its enable bit is set. The masked status bits are ORed onto one interrupt line. Software reads the masked status and writes the same word to the clear register to acknowledge the latched edges.

The register port is a plain control interface. An access happens in any cycle where `reg_valid` is high. There is no back-pressure: every access completes in that cycle. Read data is combinational from the address. Writes take effect at the next rising clock edge.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset: direction reads 0x0000, output data reads 0x0000, enable reads 0x0000, mask reads 0xFFFF, masked status reads 0x0000, `irq` is 0 and `gpio_oe` is 0.
- R2: The direction register is read/write at offset 0x00. A bit of 1 makes the pin an output, and `gpio_oe` equals the register value in the cycle after the write.
- R3: Writing to offset 0x18 sets every output latch bit that is 1 in the written word and leaves the other bits unchanged. Reads of offset 0x18 return zero.
- R4: Writing to offset 0x1C clears every output latch bit that is 1 in the written word and leaves the other bits unchanged. Reads of offset 0x1C return zero.
- R5: Offset 0x20 reads back the output latch, and `gpio_out` equals it. The latch changes only on writes to 0x18 or 0x1C.
- R6: Offset 0x14 returns the pin inputs after two-flop synchronisation. A pin change is still unseen after one rising edge and is seen after the second.
- R7: When a pin's level-select bit (offset 0x04) is 1, its raw status equals its synchronised level. The level is active-high when the polarity bit (offset 0x08) is 1 and active-low when it is 0. A clear write does not drop status while the level stays active.
- R8: When the level-select bit is 0, a rising edge sets the sticky status if the rise enable (offset 0x0C) is 1. A falling edge sets it if the fall enable (offset 0x10) is 1. Both enables together trigger on either edge. The status stays set after the pin returns.
- R9: Masked status at offset 0x30 is raw status AND NOT mask (offset 0x28) AND enable (offset 0x2C). Edges still latch while a pin is masked or disabled, and they appear once the gating is lifted.
- R10: Writing a 1 to a bit of offset 0x34 clears that pin's latched edge status. Zero bits in the written word leave the other pins' latched status unchanged.
- R11: `irq` is 1 exactly when the masked status is non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access in this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset of register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data (combinational) |
| gpio_in | input | 16 | Pin input levels (asynchronous) |
| gpio_out | output | 16 | Output latch |
| gpio_oe | output | 16 | Output enable per pin (direction) |
| irq | output | 1 | OR of all masked status bits |

## Verification
Directed sequences cover each trigger kind on its own: rising only, falling only, both edges, and active-high and active-low levels. This separates the independent edge enables from a shared toggle detector, and separates the level path from the sticky latch. Random runs mix pin toggles, configuration writes, mask and enable changes, and partial clears, and compare them against a bench model of the sticky edge state. This exposes lost or spurious latching, wrong gating order and clears that touch the wrong pins. Set/clear strobes with overlapping random words show whether zero bits really leave the other pins untouched.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_DIR   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_LSEL  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_LPOL  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_RISE  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_FALL  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_DIN   = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_SET   = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_DOUT  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_EN    = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_MSTAT = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_ICLR  = 8'h34;

  typedef struct packed {
    logic [15:0] lsel;
    logic [15:0] lpol;
    logic [15:0] rise;
    logic [15:0] fall;
    logic [15:0] mask;
    logic [15:0] en;
  } trig_cfg_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_trigger.sv
module gpio_trigger
  import gpio_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_s,
  input  trig_cfg_t    cfg,
  input  logic         clr_we,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] raw_status,
  output logic [W-1:0] masked_status
);
  logic [W-1:0] prev_q;
  logic [W-1:0] edge_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin_s;
  end

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_pin
      logic hit;
      logic drop;
      // An edge is only latched while the pin is in edge mode. A new
      // detection in the same cycle as a clear keeps the bit set.
      assign hit  = ~cfg.lsel[i] &
                    ((cfg.rise[i] &  pin_s[i] & ~prev_q[i]) |
                     (cfg.fall[i] & ~pin_s[i] &  prev_q[i]));
      assign drop = clr_we & clr_bits[i];

      always_ff @(posedge clk) begin
        if (!rst_n) edge_q[i] <= 1'b0;
        else        edge_q[i] <= (edge_q[i] & ~drop) | hit;
      end

      assign raw_status[i]    = cfg.lsel[i] ? ~(pin_s[i] ^ cfg.lpol[i]) : edge_q[i];
      assign masked_status[i] = raw_status[i] & ~cfg.mask[i] & cfg.en[i];
    end
  endgenerate
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  input  logic [W-1:0]      din_s,
  input  logic [W-1:0]      mstat,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      dout_q,
  output trig_cfg_t         cfg,
  output logic              clr_we
);
  logic wr;
  logic [W-1:0] lsel_q, lpol_q, rise_q, fall_q, mask_q, en_q;

  assign wr     = reg_valid & reg_write;
  assign clr_we = wr && (reg_addr == OFS_ICLR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= '0;
      lsel_q <= '0;
      lpol_q <= '0;
      rise_q <= '0;
      fall_q <= '0;
      dout_q <= '0;
      mask_q <= '1;
      en_q   <= '0;
    end else if (wr) begin
      case (reg_addr)
        OFS_DIR:  dir_q  <= reg_wdata;
        OFS_LSEL: lsel_q <= reg_wdata;
        OFS_LPOL: lpol_q <= reg_wdata;
        OFS_RISE: rise_q <= reg_wdata;
        OFS_FALL: fall_q <= reg_wdata;
        OFS_SET:  dout_q <= dout_q | reg_wdata;
        OFS_CLR:  dout_q <= dout_q & ~reg_wdata;
        OFS_MASK: mask_q <= reg_wdata;
        OFS_EN:   en_q   <= reg_wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    cfg.lsel = lsel_q;
    cfg.lpol = lpol_q;
    cfg.rise = rise_q;
    cfg.fall = fall_q;
    cfg.mask = mask_q;
    cfg.en   = en_q;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_valid && !reg_write) begin
      case (reg_addr)
        OFS_DIR:   reg_rdata = dir_q;
        OFS_LSEL:  reg_rdata = lsel_q;
        OFS_LPOL:  reg_rdata = lpol_q;
        OFS_RISE:  reg_rdata = rise_q;
        OFS_FALL:  reg_rdata = fall_q;
        OFS_DIN:   reg_rdata = din_s;
        OFS_DOUT:  reg_rdata = dout_q;
        OFS_MASK:  reg_rdata = mask_q;
        OFS_EN:    reg_rdata = en_q;
        OFS_MSTAT: reg_rdata = mstat;
        default:   reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned N_PINS      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [N_PINS-1:0] reg_wdata,
  output logic [N_PINS-1:0] reg_rdata,
  input  logic [N_PINS-1:0] gpio_in,
  output logic [N_PINS-1:0] gpio_out,
  output logic [N_PINS-1:0] gpio_oe,
  output logic              irq
);
  logic [N_PINS-1:0] pin_s;
  logic [N_PINS-1:0] raw_status;
  logic [N_PINS-1:0] masked_status;
  logic [N_PINS-1:0] dir_q;
  logic [N_PINS-1:0] dout_q;
  trig_cfg_t         cfg;
  logic              clr_we;

  gpio_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (gpio_in),
    .sync_out (pin_s)
  );

  gpio_regfile #(.W(N_PINS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_valid (reg_valid),
    .reg_write (reg_write),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .din_s     (pin_s),
    .mstat     (masked_status),
    .dir_q     (dir_q),
    .dout_q    (dout_q),
    .cfg       (cfg),
    .clr_we    (clr_we)
  );

  gpio_trigger #(.W(N_PINS)) u_trig (
    .clk           (clk),
    .rst_n         (rst_n),
    .pin_s         (pin_s),
    .cfg           (cfg),
    .clr_we        (clr_we),
    .clr_bits      (reg_wdata),
    .raw_status    (raw_status),
    .masked_status (masked_status)
  );

  assign gpio_out = dout_q;
  assign gpio_oe  = dir_q;
  assign irq      = |masked_status;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_valid,
  input logic              reg_write,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [W-1:0]      reg_wdata,
  input logic [W-1:0]      gpio_out,
  input logic [W-1:0]      gpio_oe,
  input logic [W-1:0]      mask_q,
  input logic [W-1:0]      en_q,
  input logic              irq
);
  logic wr_dir, wr_set, wr_clr;
  assign wr_dir = reg_valid && reg_write && (reg_addr == OFS_DIR);
  assign wr_set = reg_valid && reg_write && (reg_addr == OFS_SET);
  assign wr_clr = reg_valid && reg_write && (reg_addr == OFS_CLR);

  // R2
  oe_follows_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> gpio_oe == $past(reg_wdata));

  // R3
  set_reaches_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> (gpio_out & $past(reg_wdata)) == $past(reg_wdata));

  // R4
  clr_reaches_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> (gpio_out & $past(reg_wdata)) == '0);

  // R5
  out_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_set || wr_clr) |=> $stable(gpio_out));

  // R11
  irq_needs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en_q & ~mask_q) != '0);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.W(N_PINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_valid (reg_valid),
  .reg_write (reg_write),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .gpio_out  (gpio_out),
  .gpio_oe   (gpio_oe),
  .mask_q    (cfg.mask),
  .en_q      (cfg.en),
  .irq       (irq)
);

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;
  localparam logic [7:0] A_DIR = 8'h00, A_LSEL = 8'h04, A_LPOL = 8'h08,
                         A_RISE = 8'h0C, A_FALL = 8'h10, A_DIN = 8'h14,
                         A_SET = 8'h18, A_CLR = 8'h1C, A_DOUT = 8'h20,
                         A_MASK = 8'h28, A_EN = 8'h2C, A_MST = 8'h30,
                         A_ICLR = 8'h34;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 1'b0;
  logic        reg_write = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [15:0] gpio_in = '0;
  logic [15:0] gpio_out;
  logic [15:0] gpio_oe;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // model state
  logic [15:0] m_lsel, m_lpol, m_rise, m_fall, m_mask, m_en, m_edge, m_pin, m_dout;

  always #5 clk = ~clk;

  gpio_irq_ctrl u_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
    case (a)
      A_LSEL: m_lsel = d;
      A_LPOL: m_lpol = d;
      A_RISE: m_rise = d;
      A_FALL: m_fall = d;
      A_MASK: m_mask = d;
      A_EN:   m_en   = d;
      A_SET:  m_dout = m_dout | d;
      A_CLR:  m_dout = m_dout & ~d;
      A_ICLR: m_edge = m_edge & ~d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    reg_valid = 1'b0;
  endtask

  // change pins, let them settle through sync and edge latch
  task automatic pins(input logic [15:0] v);
    @(negedge clk);
    gpio_in = v;
    m_edge = m_edge | (((v & ~m_pin & m_rise) | (~v & m_pin & m_fall)) & ~m_lsel);
    m_pin = v;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [15:0] exp_mst();
    logic [15:0] raw;
    raw = (m_lsel & ~(m_pin ^ m_lpol)) | (~m_lsel & m_edge);
    return raw & ~m_mask & m_en;
  endfunction

  task automatic check_status(input string req);
    logic [15:0] d;
    @(negedge clk);
    rd(A_MST, d);
    chk(req, d, exp_mst());
    chk("R11", {15'd0, irq}, {15'd0, exp_mst() != 0});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] d, v;
    void'($urandom(32'h5eed1234));
    m_lsel = 0; m_lpol = 0; m_rise = 0; m_fall = 0; m_mask = 16'hFFFF;
    m_en = 0; m_edge = 0; m_pin = 0; m_dout = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_DIR, d);  chk("R1", d, 16'h0000);
    rd(A_DOUT, d); chk("R1", d, 16'h0000);
    rd(A_EN, d);   chk("R1", d, 16'h0000);
    rd(A_MASK, d); chk("R1", d, 16'hFFFF);
    rd(A_MST, d);  chk("R1", d, 16'h0000);
    chk("R1", {15'd0, irq}, 16'h0000);
    chk("R1", gpio_oe, 16'h0000);

    // R2 direction
    wr(A_DIR, 16'hA50F);
    chk("R2", gpio_oe, 16'hA50F);
    rd(A_DIR, d); chk("R2", d, 16'hA50F);

    // R3 R4 R5 set/clear strobes
    wr(A_SET, 16'h00FF);
    chk("R3", gpio_out, 16'h00FF);
    wr(A_SET, 16'h0F00);
    chk("R3", gpio_out, 16'h0FFF);
    rd(A_SET, d); chk("R3", d, 16'h0000);
    wr(A_CLR, 16'h0110);
    chk("R4", gpio_out, 16'h0EEF);
    rd(A_CLR, d); chk("R4", d, 16'h0000);
    rd(A_DOUT, d); chk("R5", d, 16'h0EEF);
    wr(A_MASK, 16'hFFFF);
    chk("R5", gpio_out, 16'h0EEF);

    // R6 synchroniser latency
    @(negedge clk);
    gpio_in = 16'h8001;
    @(posedge clk); #1;
    rd(A_DIN, d); chk("R6", d, 16'h0000);
    @(posedge clk); #1;
    rd(A_DIN, d); chk("R6", d, 16'h8001);
    gpio_in = 16'h0000;
    repeat (4) @(negedge clk);

    // open gating for all pins
    wr(A_MASK, 16'h0000);
    wr(A_EN, 16'hFFFF);

    // R8 rising only on pin0, falling only on pin1, both on pin2
    wr(A_RISE, 16'h0005);
    wr(A_FALL, 16'h0006);
    pins(16'h0007);
    check_status("R8");   // pin0, pin2 rose
    pins(16'h0000);
    check_status("R8");   // pin1, pin2 fell; all sticky
    wr(A_ICLR, 16'h0001); // R10 partial clear
    check_status("R10");
    wr(A_ICLR, 16'hFFFF);
    check_status("R10");

    // R7 level, active high on pin4, active low on pin5
    wr(A_LSEL, 16'h0030);
    wr(A_LPOL, 16'h0010);
    check_status("R7");   // pin5 low -> active
    pins(16'h0010);
    check_status("R7");
    wr(A_ICLR, 16'hFFFF);
    check_status("R7");   // still active after clear

    // R9 edge latches while masked
    wr(A_LSEL, 16'h0000);
    wr(A_RISE, 16'h0100);
    wr(A_MASK, 16'h0100);
    pins(16'h0110);
    check_status("R9");
    wr(A_MASK, 16'h0000);
    check_status("R9");
    wr(A_EN, 16'h0000);
    check_status("R9");
    wr(A_EN, 16'hFFFF);
    wr(A_ICLR, 16'hFFFF);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int k;
      v = 16'($urandom);
      k = $urandom_range(0, 9);
      case (k)
        0: wr(A_LSEL, v & 16'($urandom));
        1: wr(A_LPOL, v);
        2: wr(A_RISE, v);
        3: wr(A_FALL, v);
        4: wr(A_MASK, v & 16'($urandom));
        5: wr(A_EN, v | 16'($urandom));
        6: wr(A_ICLR, v);
        7: begin
          wr(A_SET, v);
          chk("R3", gpio_out, m_dout);
        end
        8: begin
          wr(A_CLR, v);
          chk("R4", gpio_out, m_dout);
        end
        default: pins(v);
      endcase
      check_status("R9");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule